// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, blanking and display-enable signals for a raster display, together with the pixel column and row of the current active pixel and a pulse that marks the first pixel of each frame. It runs on the pixel clock. A small set of timing registers defines each axis. On the horizontal axis one count covers a group of pixels, and the group size is 4, 8 or 16 pixel clocks. On the vertical axis one count is one line.

Each axis is described by four positions, all measured from the leading edge of sync: where sync ends, where blanking ends, where blanking starts again, and the last count of the axis. The visible width in counts is blank-start minus blank-end. For example, a 1280-pixel line at group size 8 needs a span of 160 counts. If the span is set wider than the real line, active pixels run into the horizontal blanking interval.

Software can rewrite the timing while the block is running. Each write lands in a shadow copy. The working copy is reloaded from the shadow only as the counters roll over into a new frame, so no frame ever mixes old and new timing. The reset timing is given by parameters and defaults to a 1280x1024 layout at group size 8.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all counters are zero and the working timing equals the reset parameters. In the first cycle after reset, hsync, vsync, blank and frame_start are 1, de is 0, and pix_x and pix_y are 0.
- R2: A group counter counts pixel clocks from 0 to M-1, where M is 4, 8 or 16 for size codes 00, 01 or 10; code 11 acts as 4. The horizontal count advances each time the group counter wraps, and returns to 0 after it reaches h_total. A line therefore lasts (h_total+1)*M clocks.
- R3: The line count advances once per line and returns to 0 after it reaches v_total. A frame therefore lasts (v_total+1) lines.
- R4: hsync is 1 while the horizontal count is below h_sync_end. vsync is 1 while the line count is below v_sync_end.
- R5: An axis is blanked while its count is below its blank_end or at or above its blank_start. blank is the OR of the two axes, and de is the inverse of blank.
- R6: While de is 1, pix_x = (horizontal count - h_blank_end)*M + group index and pix_y = line count - v_blank_end. While de is 0, both are 0. A line's active run is (h_blank_start - h_blank_end)*M clocks long, with pix_x running from 0 up by one each clock.
- R7: frame_start is 1 for exactly one clock, the clock in which the group, horizontal and line counts are all 0.
- R8: Register map on cfg_addr: 0 h_sync_end, 1 h_blank_end, 2 h_blank_start, 3 h_total, 4 v_sync_end, 5 v_blank_end, 6 v_blank_start, 7 v_total, 8 group size code in cfg_wdata[1:0]. Writes to any other address change nothing.
- R9: A write goes to the shadow copy. It becomes effective at the next frame rollover, so the frame in progress keeps its timing. A write made in the last clock of a frame misses that rollover and takes effect one frame later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 12 | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Blanking, horizontal or vertical |
| de | output | 1 | Display enable |
| pix_x | output | 16 | Active pixel column |
| pix_y | output | 16 | Active pixel row |
| frame_start | output | 1 | One-clock pulse on the first pixel of each frame |

## Verification
A cycle-by-cycle reference model runs in parallel with the block across all of the following patterns.

- **Group sizes.** Group sizes 4, 8 and 16 and the spare code 11 are each run with different horizontal layouts. Frame length and active-run length separate a wrong group size from a wrong total or a wrong blank span.
- **Write timing.** A write made in the middle of a frame is checked against the width of the very next hsync pulse, which shows whether the write leaked into the frame in progress. A write made in the last clock of a frame shows whether the reload happens one frame too early.
- **Unused addresses.** Writes to unused addresses must leave both the frame length and the active run unchanged.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int CNT_W = 12;
  parameter int PIX_W = 16;
  parameter int SUB_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t sync_end;
    cnt_t blank_end;
    cnt_t blank_start;
    cnt_t total;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t  h;
    axis_cfg_t  v;
    logic [1:0] mult;
  } timing_cfg_t;

  // log2 of the pixel group size; the spare code behaves as the smallest group
  function automatic logic [2:0] grp_shift(input logic [1:0] code);
    case (code)
      2'b01:   grp_shift = 3'd3;
      2'b10:   grp_shift = 3'd4;
      default: grp_shift = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
  import raster_pkg::*;
#(
  parameter timing_cfg_t RST_CFG = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic        frame_wrap,
  output timing_cfg_t live
);
  timing_cfg_t shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= RST_CFG;
      live   <= RST_CFG;
    end else begin
      if (frame_wrap) live <= shadow;
      if (we) begin
        case (addr)
          4'd0: shadow.h.sync_end    <= wdata;
          4'd1: shadow.h.blank_end   <= wdata;
          4'd2: shadow.h.blank_start <= wdata;
          4'd3: shadow.h.total       <= wdata;
          4'd4: shadow.v.sync_end    <= wdata;
          4'd5: shadow.v.blank_end   <= wdata;
          4'd6: shadow.v.blank_start <= wdata;
          4'd7: shadow.v.total       <= wdata;
          4'd8: shadow.mult          <= wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  // R9: the working timing only moves at a frame rollover
  a_r9_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_wrap) |-> $stable(live));
endmodule

// File: rtl/raster_counters.sv
module raster_counters
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  timing_cfg_t cfg,
  output logic [SUB_W-1:0] sub,
  output cnt_t        hcnt,
  output cnt_t        vcnt,
  output logic        frame_wrap
);
  logic [SUB_W-1:0] sub_max;
  logic sub_last, h_last, v_last;

  assign sub_max    = SUB_W'((1 << grp_shift(cfg.mult)) - 1);
  assign sub_last   = (sub == sub_max);
  assign h_last     = (hcnt >= cfg.h.total);
  assign v_last     = (vcnt >= cfg.v.total);
  assign frame_wrap = sub_last && h_last && v_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub  <= '0;
      hcnt <= '0;
      vcnt <= '0;
    end else if (sub_last) begin
      sub <= '0;
      if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else begin
      sub <= sub + 1'b1;
    end
  end

  a_r2_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= sub_max);
  a_r2_h_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= cfg.h.total);
  a_r3_v_step: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> ($past(hcnt) == $past(cfg.h.total) && $past(sub) == $past(sub_max)));
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
(
  input  timing_cfg_t      cfg,
  input  logic [SUB_W-1:0] sub,
  input  cnt_t             hcnt,
  input  cnt_t             vcnt,
  output logic             hsync,
  output logic             vsync,
  output logic             blank,
  output logic             de,
  output logic [PIX_W-1:0] pix_x,
  output logic [PIX_W-1:0] pix_y,
  output logic             frame_start
);
  logic h_blank, v_blank;
  logic [PIX_W-1:0] col_grp;

  always_comb begin
    hsync   = (hcnt < cfg.h.sync_end);
    vsync   = (vcnt < cfg.v.sync_end);
    h_blank = (hcnt < cfg.h.blank_end) || (hcnt >= cfg.h.blank_start);
    v_blank = (vcnt < cfg.v.blank_end) || (vcnt >= cfg.v.blank_start);
    blank   = h_blank || v_blank;
    de      = !blank;
    col_grp = PIX_W'(cnt_t'(hcnt - cfg.h.blank_end));
    pix_x   = de ? ((col_grp << grp_shift(cfg.mult)) + PIX_W'(sub)) : '0;
    pix_y   = de ? PIX_W'(cnt_t'(vcnt - cfg.v.blank_end)) : '0;
    frame_start = (sub == '0) && (hcnt == '0) && (vcnt == '0);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int RST_H_SYNC_END    = 15,
  parameter int RST_H_BLANK_END   = 35,
  parameter int RST_H_BLANK_START = 195,
  parameter int RST_H_TOTAL       = 215,
  parameter int RST_V_SYNC_END    = 2,
  parameter int RST_V_BLANK_END   = 42,
  parameter int RST_V_BLANK_START = 1066,
  parameter int RST_V_TOTAL       = 1069,
  parameter int RST_MULT          = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [11:0]      cfg_wdata,
  output logic             hsync,
  output logic             vsync,
  output logic             blank,
  output logic             de,
  output logic [15:0]      pix_x,
  output logic [15:0]      pix_y,
  output logic             frame_start
);
  localparam timing_cfg_t RST_CFG = '{
    h: '{sync_end: cnt_t'(RST_H_SYNC_END), blank_end: cnt_t'(RST_H_BLANK_END),
         blank_start: cnt_t'(RST_H_BLANK_START), total: cnt_t'(RST_H_TOTAL)},
    v: '{sync_end: cnt_t'(RST_V_SYNC_END), blank_end: cnt_t'(RST_V_BLANK_END),
         blank_start: cnt_t'(RST_V_BLANK_START), total: cnt_t'(RST_V_TOTAL)},
    mult: 2'(RST_MULT)
  };

  timing_cfg_t      live;
  logic [SUB_W-1:0] sub;
  cnt_t             hcnt, vcnt;
  logic             frame_wrap;

  raster_cfg_regs #(.RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_wrap(frame_wrap), .live(live)
  );

  raster_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .cfg(live), .sub(sub), .hcnt(hcnt), .vcnt(vcnt),
    .frame_wrap(frame_wrap)
  );

  raster_decode u_dec (
    .cfg(live), .sub(sub), .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync), .vsync(vsync),
    .blank(blank), .de(de), .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
  );

  // R7: the frame marker never lasts two clocks
  a_r7_fs_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R6: within an active run the column steps by one
  a_r6_pix_step: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && pix_x != '0) |-> (pix_x == $past(pix_x) + 16'd1));
  // R5: display enable and blank are never both asserted
  a_r5_de_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !(de && blank));
  // R1: reset yields the frame origin on the next clock
  a_r1_reset_origin: assert property (@(posedge clk)
    !rst_n |=> (frame_start && hsync == (RST_H_SYNC_END > 0)));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic hsync, vsync, blank, de, frame_start;
  logic [15:0] pix_x, pix_y;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  raster_timing_gen #(
    .RST_H_SYNC_END(2), .RST_H_BLANK_END(4), .RST_H_BLANK_START(12), .RST_H_TOTAL(14),
    .RST_V_SYNC_END(1), .RST_V_BLANK_END(2), .RST_V_BLANK_START(6), .RST_V_TOTAL(7),
    .RST_MULT(0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync(hsync), .vsync(vsync), .blank(blank), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .frame_start(frame_start)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d at cycle %0d", req, what, got, exp, cyc);
    end
  endtask

  // reference model: registers 0..8 as listed in R8
  int live_c[9];
  int shad_c[9];
  int e_sub, e_h, e_v;

  function automatic int grp(input int code);
    return (code == 1) ? 8 : (code == 2) ? 16 : 4;
  endfunction

  task automatic model_init();
    int rv[9] = '{2, 4, 12, 14, 1, 2, 6, 7, 0};
    for (int i = 0; i < 9; i++) begin live_c[i] = rv[i]; shad_c[i] = rv[i]; end
    e_sub = 0; e_h = 0; e_v = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    if (!rst_n) begin
      model_init();
    end else begin
      int m, ex, ey;
      bit hb, vb, eb, wrap;
      m  = grp(live_c[8]);
      hb = (e_h < live_c[1]) || (e_h >= live_c[2]);
      vb = (e_v < live_c[5]) || (e_v >= live_c[6]);
      eb = hb || vb;
      ex = eb ? 0 : (e_h - live_c[1]) * m + e_sub;
      ey = eb ? 0 : e_v - live_c[5];
      check("R4", "hsync", hsync, e_h < live_c[0]);
      check("R4", "vsync", vsync, e_v < live_c[4]);
      check("R5", "blank", blank, eb);
      check("R5", "de", de, !eb);
      check("R6", "pix_x", pix_x, ex);
      check("R6", "pix_y", pix_y, ey);
      check("R7", "frame_start", frame_start, (e_sub == 0 && e_h == 0 && e_v == 0));
      wrap = 0;
      if (e_sub == m - 1) begin
        e_sub = 0;
        if (e_h >= live_c[3]) begin
          e_h = 0;
          if (e_v >= live_c[7]) begin e_v = 0; wrap = 1; end
          else e_v++;
        end else e_h++;
      end else e_sub++;
      if (wrap) for (int i = 0; i < 9; i++) live_c[i] = shad_c[i];
      if (cfg_we && cfg_addr <= 8)
        shad_c[cfg_addr] = (cfg_addr == 8) ? (cfg_wdata & 3) : cfg_wdata;
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 12'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  // called at a negedge showing frame_start; ends on the next one
  task automatic frame_len(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_start);
  endtask

  task automatic hsync_width(output int n);
    logic p;
    p = hsync;
    forever begin @(negedge clk); if (hsync && !p) break; p = hsync; end
    n = 0;
    while (hsync) begin n++; @(negedge clk); end
  endtask

  task automatic de_run(output int n, output int x0, output int xl);
    logic p;
    p = de;
    forever begin @(negedge clk); if (de && !p) break; p = de; end
    n = 0; x0 = pix_x; xl = pix_x;
    while (de) begin n++; xl = pix_x; @(negedge clk); end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset hsync", hsync, 1);
    check("R1", "reset vsync", vsync, 1);
    check("R1", "reset blank", blank, 1);
    check("R1", "reset de", de, 0);
    check("R1", "reset frame_start", frame_start, 1);
    check("R1", "reset pix_x", pix_x, 0);
    check("R1", "reset pix_y", pix_y, 0);
  endtask

  task automatic t_x4_default();
    int n, x0, xl;
    wait_fs();
    frame_len(n);
    check("R2", "x4 frame length", n, 480);
    de_run(n, x0, xl);
    check("R6", "x4 active run", n, 32);
    check("R6", "x4 first column", x0, 0);
    check("R6", "x4 last column", xl, 31);
  endtask

  task automatic t_x8_midframe();
    int n, x0, xl;
    wait_fs();
    repeat (10) @(posedge clk);
    wr(0, 3); wr(1, 5); wr(2, 13); wr(3, 15); wr(8, 1);
    hsync_width(n);
    check("R9", "hsync width before rollover", n, 8);
    wait_fs();
    frame_len(n);
    check("R2", "x8 frame length", n, 1024);
    de_run(n, x0, xl);
    check("R6", "x8 active run", n, 64);
    check("R6", "x8 last column", xl, 63);
  endtask

  task automatic t_x16();
    int n, x0, xl;
    wr(0, 1); wr(1, 2); wr(2, 6); wr(3, 7); wr(8, 2);
    wait_fs();
    frame_len(n);
    check("R2", "x16 frame length", n, 1024);
    de_run(n, x0, xl);
    check("R6", "x16 active run", n, 64);
    check("R6", "x16 last column", xl, 63);
  endtask

  task automatic t_spare_code();
    int n, x0, xl;
    wr(8, 3);
    wait_fs();
    frame_len(n);
    check("R2", "code 11 frame length", n, 256);
    de_run(n, x0, xl);
    check("R2", "code 11 active run", n, 16);
  endtask

  task automatic t_last_cycle_write();
    int n;
    wait_fs();
    repeat (255) @(posedge clk);
    #1 cfg_we = 1'b1; cfg_addr = 4'd7; cfg_wdata = 12'd5;
    @(posedge clk); #1 cfg_we = 1'b0;
    wait_fs();
    frame_len(n);
    check("R9", "frame after last-cycle write", n, 256);
    frame_len(n);
    check("R3", "frame with v_total 5", n, 192);
  endtask

  task automatic t_unused_addr();
    int n, x0, xl;
    wr(9, 0); wr(15, 1); wr(12, 0);
    wait_fs();
    wait_fs();
    frame_len(n);
    check("R8", "frame length after unused writes", n, 192);
    de_run(n, x0, xl);
    check("R8", "active run after unused writes", n, 16);
  endtask

  initial begin
    t_reset();
    t_x4_default();
    t_x8_midframe();
    t_x16();
    t_spare_code();
    t_last_cycle_write();
    t_unused_addr();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule